// File: doc/BRIEF.md
# Line Rate Autonegotiation Sequencer

This controller brings up a serial fronthaul link whose line rate is not known in advance. After a start strobe it tries a fixed list of candidate rates in order. For each candidate it first sets the reference-clock select to suit that rate. It then runs a two-phase PLL reconfiguration handshake: a load-from-ROM request, followed by an apply request once the busy input has fallen. When the reconfiguration-done indication drops, it resets the ROM address. It then writes the candidate's rate code and waits for the core to echo that code back. Last, it watches the 2-bit receive status for frame synchronization.

In the optional confirmation mode, the transmitter enable is dropped when the rate code is written. It is raised again once the receiver reports its intermediate state. Every wait has a cycle timeout, set from an input, and a timeout moves on to the next candidate. Success raises a locked flag and holds the rate code until the next start. If the last candidate fails, a fail flag is raised and the sequencer goes idle.

Top module: `lrate_neg_seq`

## Requirements
- R1: After reset `rom_load`, `reconf_go`, `rom_addr_rst`, `locked`, `failed`, `rate_code` and `refclk_sel` are all 0, and `tx_en` is 1.
- R2: A `start` pulse, whether the sequencer is idle, locked or failed, begins a run at candidate entry 0. Before each `rom_load` pulse, `refclk_sel` equals bits [3:2] of that candidate's 4-bit code.
- R3: Each candidate begins with a `rom_load` pulse that lasts one cycle. The sequencer then waits for `busy` to rise and then to fall.
- R4: After `busy` falls, `reconf_go` pulses for one cycle and never while `busy` is still high. The sequencer then waits for `busy` to rise and for `reconf_done` to fall from 1 to 0.
- R5: The falling edge of `reconf_done` is followed by a one-cycle `rom_addr_rst` pulse, and there is none before that edge.
- R6: Two cycles after the `rom_addr_rst` pulse, `rate_code` holds the candidate's code. The sequencer goes further only when `rate_ack` equals `rate_code`.
- R7: When `confirm_mode` is 1 at start, `tx_en` is 0 from the rate write until `rx_stat` equals 2'b01, and it returns to 1 in the cycle after that. If that wait times out, `tx_en` is 1 again before the next candidate begins.
- R8: In the synchronization wait, `rx_stat` equal to 2'b11 sets `locked` in the next cycle. `locked` and `rate_code` then stay unchanged until `start`, whatever the other inputs do.
- R9: A wait state that lasts longer than `tmo_limit` cycles abandons the candidate, and the next list entry is tried in order.
- R10: A timeout on the last entry sets `failed` and returns to idle. `failed` then holds until `start`, and `locked` and `failed` are never 1 together.
- R11: Candidate entry i is bits [4i+3:4i] of the `RATE_LIST` parameter. The default list gives entry i the code i+1, for 8 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a new negotiation run |
| confirm_mode | input | 1 | Enables the tx gating step, sampled at start |
| tmo_limit | input | TMO_W | Cycle timeout for every wait state |
| busy | input | 1 | Busy from the PLL reconfiguration logic |
| reconf_done | input | 1 | Reconfiguration-done indication |
| rate_ack | input | 4 | Rate code echoed back by the core |
| rx_stat | input | 2 | Receive status, 2'b01 intermediate and 2'b11 synchronized |
| refclk_sel | output | 2 | Reference-clock select |
| rom_load | output | 1 | Load-from-ROM request pulse |
| reconf_go | output | 1 | Apply-reconfiguration request pulse |
| rom_addr_rst | output | 1 | ROM address reset pulse |
| rate_code | output | 4 | Rate-select code written to the core |
| tx_en | output | 1 | Transmitter enable |
| locked | output | 1 | Synchronization reached |
| failed | output | 1 | All candidates exhausted |

## Verification
Each candidate sees busy and done pulses of random length, which tests that every request waits for its own edge and not for a fixed delay. Failing candidates are chosen at random from a missing rate echo, a missing intermediate status and a missing synchronization status. These show whether each wait times out on its own and whether the list is walked in order. Runs with and without confirmation mode tell apart the two paths through the tx gating. A run in which every candidate fails, followed by a restart, covers the fail flag and its clearing.

// File: rtl/lrn_pkg.sv
package lrn_pkg;
    localparam int CODE_W = 4;
    localparam int REF_W  = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_REFCLK, ST_LOAD, ST_LHI, ST_LLO, ST_APPLY, ST_AHI,
        ST_ADONE, ST_ADDR, ST_RATE, ST_ACK, ST_MID, ST_SYNC, ST_LOCK
    } seq_state_t;

    localparam logic [1:0] RX_MID  = 2'b01;
    localparam logic [1:0] RX_SYNC = 2'b11;

    // reference clock choice derived from the upper code bits
    function automatic logic [REF_W-1:0] ref_of(input code_t c);
        return c[CODE_W-1 -: REF_W];
    endfunction

    function automatic logic is_wait(input seq_state_t s);
        return (s == ST_LHI) || (s == ST_LLO) || (s == ST_AHI) || (s == ST_ADONE) ||
               (s == ST_ACK) || (s == ST_MID) || (s == ST_SYNC);
    endfunction
endpackage

// File: rtl/lrn_timer.sv
module lrn_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/lrn_cand.sv
module lrn_cand
    import lrn_pkg::*;
#(
    parameter int                     N_RATES   = 8,
    parameter logic [N_RATES*CODE_W-1:0] RATE_LIST = 32'h8765_4321
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output code_t            code,
    output logic [REF_W-1:0] ref_sel,
    output logic             is_last
);
    localparam int IDX_W = (N_RATES > 1) ? $clog2(N_RATES) : 1;

    code_t            tbl [N_RATES];
    logic [IDX_W-1:0] idx_q;

    for (genvar g = 0; g < N_RATES; g++) begin : g_tbl
        assign tbl[g] = RATE_LIST[g*CODE_W +: CODE_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx_q <= '0;
        else if (adv && !is_last)
            idx_q <= idx_q + 1'b1;
    end

    assign code    = tbl[idx_q];
    assign ref_sel = ref_of(code);
    assign is_last = (idx_q == IDX_W'(N_RATES - 1));

    assert_idx_range_R11: assert property (@(posedge clk) disable iff (rst)
        (32'(idx_q) < N_RATES));
    assert_adv_order_R9: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && !is_last) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/lrate_neg_seq.sv
module lrate_neg_seq
    import lrn_pkg::*;
#(
    parameter int                        N_RATES   = 8,
    parameter int                        TMO_W     = 16,
    parameter logic [N_RATES*CODE_W-1:0] RATE_LIST = 32'h8765_4321
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              confirm_mode,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              busy,
    input  logic              reconf_done,
    input  logic [CODE_W-1:0] rate_ack,
    input  logic [1:0]        rx_stat,
    output logic [REF_W-1:0]  refclk_sel,
    output logic              rom_load,
    output logic              reconf_go,
    output logic              rom_addr_rst,
    output logic [CODE_W-1:0] rate_code,
    output logic              tx_en,
    output logic              locked,
    output logic              failed
);
    seq_state_t       st_q, st_d;
    logic             tmo, cand_clr, cand_adv, is_last, mode_q, done_q;
    code_t            cand_code;
    logic [REF_W-1:0] cand_ref;
    logic             give_up, go;

    lrn_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst(rst), .clr(st_d != st_q), .limit(tmo_limit), .expired(tmo)
    );

    lrn_cand #(.N_RATES(N_RATES), .RATE_LIST(RATE_LIST)) u_cand (
        .clk(clk), .rst(rst), .clr(cand_clr), .adv(cand_adv),
        .code(cand_code), .ref_sel(cand_ref), .is_last(is_last)
    );

    assign go       = start && (st_q == ST_IDLE || st_q == ST_LOCK);
    assign cand_clr = go;

    always_comb begin
        st_d     = st_q;
        give_up  = 1'b0;
        cand_adv = 1'b0;
        unique case (st_q)
            ST_IDLE:   if (go) st_d = ST_REFCLK;
            ST_REFCLK: st_d = ST_LOAD;
            ST_LOAD:   st_d = ST_LHI;
            ST_LHI:    if (busy) st_d = ST_LLO;
            ST_LLO:    if (!busy) st_d = ST_APPLY;
            ST_APPLY:  st_d = ST_AHI;
            ST_AHI:    if (busy) st_d = ST_ADONE;
            ST_ADONE:  if (done_q && !reconf_done) st_d = ST_ADDR;
            ST_ADDR:   st_d = ST_RATE;
            ST_RATE:   st_d = ST_ACK;
            ST_ACK:    if (rate_ack == rate_code) st_d = mode_q ? ST_MID : ST_SYNC;
            ST_MID:    if (rx_stat == RX_MID) st_d = ST_SYNC;
            ST_SYNC:   if (rx_stat == RX_SYNC) st_d = ST_LOCK;
            ST_LOCK:   if (go) st_d = ST_REFCLK;
            default:   st_d = ST_IDLE;
        endcase
        // a timeout only wins when the awaited condition is absent
        if (is_wait(st_q) && st_d == st_q && tmo) begin
            if (is_last) begin
                give_up = 1'b1;
                st_d    = ST_IDLE;
            end else begin
                cand_adv = 1'b1;
                st_d     = ST_REFCLK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            mode_q     <= 1'b0;
            done_q     <= 1'b0;
            refclk_sel <= '0;
            rate_code  <= '0;
            tx_en      <= 1'b1;
            locked     <= 1'b0;
            failed     <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= reconf_done;
            if (go) begin
                mode_q <= confirm_mode;
                locked <= 1'b0;
                failed <= 1'b0;
            end
            if (st_q == ST_REFCLK) refclk_sel <= cand_ref;
            if (st_q == ST_RATE) begin
                rate_code <= cand_code;
                if (mode_q) tx_en <= 1'b0;
            end
            if (st_q == ST_MID && st_d == ST_SYNC) tx_en <= 1'b1;
            if (cand_adv || give_up) tx_en <= 1'b1;
            if (give_up) failed <= 1'b1;
            if (st_q == ST_SYNC && st_d == ST_LOCK) locked <= 1'b1;
        end
    end

    assign rom_load     = (st_q == ST_LOAD);
    assign reconf_go    = (st_q == ST_APPLY);
    assign rom_addr_rst = (st_q == ST_ADDR);

    assert_load_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rom_load |=> !rom_load);
    assert_apply_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        reconf_go |=> !reconf_go);
    assert_addr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rom_addr_rst |=> !rom_addr_rst);
    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (locked && !start) |=> (locked && $stable(rate_code)));
    assert_fail_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (failed && !start) |=> failed);
    assert_flag_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(locked && failed));
    assert_txen_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> mode_q);
endmodule

// File: tb/lrate_neg_seq_tb.sv
module lrate_neg_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, confirm_mode = 1'b0, busy = 1'b0, reconf_done = 1'b0;
    logic [15:0] tmo_limit = 16'd20;
    logic [3:0] rate_ack = '0;
    logic [1:0] rx_stat = '0;
    logic [1:0] refclk_sel;
    logic       rom_load, reconf_go, rom_addr_rst, tx_en, locked, failed;
    logic [3:0] rate_code;
    int nchk = 0, nerr = 0;

    always #5 clk = ~clk;

    lrate_neg_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .confirm_mode(confirm_mode),
        .tmo_limit(tmo_limit), .busy(busy), .reconf_done(reconf_done),
        .rate_ack(rate_ack), .rx_stat(rx_stat), .refclk_sel(refclk_sel),
        .rom_load(rom_load), .reconf_go(reconf_go), .rom_addr_rst(rom_addr_rst),
        .rate_code(rate_code), .tx_en(tx_en), .locked(locked), .failed(failed)
    );

    function automatic int exp_code(input int i);  // R11: default entry i = i+1
        return i + 1;
    endfunction
    function automatic int exp_ref(input int i);   // R2: bits [3:2] of the code
        return (exp_code(i) >> 2) & 3;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input bit cm);
        @(negedge clk);
        confirm_mode = cm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // outcome: 0 good, 1 no rate echo, 2 no status
    task automatic run_attempt(input int idx, input int outcome, input bit cm);
        int n = 0;
        rate_ack = '0; rx_stat = 2'b00;
        while (!rom_load && n < 400) begin @(negedge clk); n++; end
        chk(rom_load, "R9 candidate attempted in order", int'(rom_load), 1);
        chk(refclk_sel == 2'(exp_ref(idx)), "R2 refclk before load", refclk_sel, exp_ref(idx));
        chk(tx_en, "R7 tx enabled at candidate start", tx_en, 1);
        @(negedge clk);
        chk(!rom_load, "R3 load pulse one cycle", rom_load, 0);
        busy = 1'b1;
        repeat (1 + $urandom % 4) begin
            @(negedge clk);
            chk(!reconf_go, "R4 no apply while busy", reconf_go, 0);
        end
        busy = 1'b0;
        n = 0;
        while (!reconf_go && n < 10) begin @(negedge clk); n++; end
        chk(reconf_go, "R4 apply after busy falls", reconf_go, 1);
        @(negedge clk);
        chk(!reconf_go, "R4 apply pulse one cycle", reconf_go, 0);
        busy = 1'b1; reconf_done = 1'b1;
        repeat (2 + $urandom % 4) begin
            @(negedge clk);
            chk(!rom_addr_rst, "R5 no addr reset before done falls", rom_addr_rst, 0);
        end
        busy = 1'b0; reconf_done = 1'b0;
        n = 0;
        while (!rom_addr_rst && n < 10) begin @(negedge clk); n++; end
        chk(rom_addr_rst, "R5 addr reset after done falls", rom_addr_rst, 1);
        @(negedge clk);
        chk(!rom_addr_rst, "R5 addr reset one cycle", rom_addr_rst, 0);
        @(negedge clk);
        chk(rate_code == 4'(exp_code(idx)), "R6 R11 rate code written", rate_code, exp_code(idx));
        if (cm) chk(!tx_en, "R7 tx off after rate write", tx_en, 0);
        if (outcome == 1) return;
        rate_ack = 4'(exp_code(idx));
        @(negedge clk);
        if (outcome == 2) begin rate_ack = '0; return; end
        if (cm) begin
            chk(!tx_en, "R7 tx off until intermediate status", tx_en, 0);
            rx_stat = 2'b01;
            @(negedge clk);
            chk(tx_en, "R7 tx back on after 01", tx_en, 1);
        end
        rx_stat = 2'b11;
        @(negedge clk);
        chk(locked, "R8 locked after 11", locked, 1);
        chk(rate_code == 4'(exp_code(idx)), "R8 final code", rate_code, exp_code(idx));
        chk(tx_en && !failed, "R8 tx on and no fail at lock", {tx_en, failed}, 2);
        rate_ack = '0; rx_stat = 2'b00;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int good;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!rom_load && !reconf_go && !rom_addr_rst, "R1 pulses low", rom_load, 0);
        chk(!locked && !failed && tx_en, "R1 flags", {locked, failed, tx_en}, 1);
        chk(rate_code == 0 && refclk_sel == 0, "R1 code and clock", rate_code, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rom_load && !locked, "R1 idle after reset", rom_load, 0);

        // directed: two failures then success, no confirmation
        pulse_start(1'b0);
        run_attempt(0, 1, 1'b0);
        run_attempt(1, 2, 1'b0);
        run_attempt(2, 0, 1'b0);
        busy = 1'b1; reconf_done = 1'b1; rate_ack = 4'hF;
        repeat (30) begin
            @(negedge clk);
            chk(locked && rate_code == 4'd3 && !rom_load, "R8 lock held", rate_code, 3);
        end
        busy = 1'b0; reconf_done = 1'b0; rate_ack = '0;

        // random: confirmation mode, random failing prefix
        for (int r = 0; r < 4; r++) begin
            good = $urandom % 8;
            pulse_start(1'b1);
            for (int i = 0; i < good; i++) run_attempt(i, 1 + $urandom % 2, 1'b1);
            run_attempt(good, 0, 1'b1);
        end

        // every candidate fails
        pulse_start(1'b1);
        for (int i = 0; i < 8; i++) run_attempt(i, 1 + $urandom % 2, 1'b1);
        begin
            int n = 0;
            while (!failed && n < 400) begin @(negedge clk); n++; end
        end
        chk(failed && !locked, "R10 fail after last entry", {failed, locked}, 2);
        chk(tx_en, "R7 tx on after fail", tx_en, 1);
        repeat (30) begin
            @(negedge clk);
            chk(failed && !rom_load, "R10 fail held, idle", failed, 1);
        end
        pulse_start(1'b0);
        chk(!failed, "R2 R10 start clears fail", failed, 0);
        run_attempt(0, 0, 1'b0);

        // restart from locked
        pulse_start(1'b0);
        chk(!locked, "R2 start clears lock", locked, 0);
        run_attempt(0, 2, 1'b0);
        run_attempt(1, 0, 1'b0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule